// File: doc/BRIEF.md
# Multichannel Audio Subframe Stream Formatter

This block takes one decoded audio sample set per sample period and turns it into a 32-bit AXI4-Stream, one word per channel. A sample set holds a 24-bit sample and a validity, a user and a channel-status bit for each of up to eight channels, along with a count of how many channels are active. Each output word packs the sample, its three flags, a parity bit and a 4-bit preamble code in a subframe layout of the IEC 60958 kind. The code tells the receiver whether the word opens an audio block, is a first subframe, or is a second subframe.

Words leave in ascending channel order, starting at channel 0, and the channel number travels on `m_tid`. A small buffer of whole sample sets absorbs backpressure from `m_tready`. If a set arrives while that buffer is full, the set is dropped and a sticky overflow flag is raised. A frame counter modulo 192 marks the first frame of each channel-status block. The stream clock must run at least 128 times faster than the audio sample rate, so one set is drained well before the next one is due.

Top module: `aud_subframe_packer`

## Requirements
- R1: Each word is laid out as follows: bits [27:4] hold the 24-bit sample of channel `m_tid`, bit 28 its validity bit, bit 29 its user bit, and bit 30 its channel-status bit.
- R2: Bit 31 is chosen so that bits [31:4] of every word hold an even number of ones.
- R3: Bits [3:0] hold the preamble code. Channel 0 of a block-start frame carries 4'b0001. Channel 0 of any other frame, and every other even channel, carries 4'b0010. Odd channels carry 4'b0011.
- R4: Within a frame, words are emitted with `m_tid` equal to the channel number, in the order 0, 1, 2 and upward to the last active channel, with no channel skipped or repeated.
- R5: `chan_cfg` selects the active channel count: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 6 and 2'b11 gives 8. It is captured together with the sample set, so a change after capture does not alter that frame.
- R6: A word transfers only on a clock where `m_tvalid` and `m_tready` are both high. While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tid` hold their values.
- R7: Up to BUF_SETS (default 2) sample sets wait in the buffer. A set that arrives while the buffer already holds BUF_SETS sets is discarded, and `ovf_flag` rises and stays high until reset.
- R8: The first frame after reset is a block-start frame, and block starts recur every 192 frames (frame index modulo 192 equal to 0).
- R9: After reset, `m_tvalid` and `ovf_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a new sample set is present |
| chan_cfg | input | 2 | Active channel count code (R5) |
| smp_data | input | 192 | Samples; channel k at bits [24k+23:24k] |
| smp_vbit | input | 8 | Validity bit per channel |
| smp_ubit | input | 8 | User bit per channel |
| smp_cbit | input | 8 | Channel-status bit per channel |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 32 | Subframe word |
| m_tid | output | 3 | Channel number of the word |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The bench targets the block-start code. It runs past frame 192 to confirm the code returns exactly there and nowhere else; a counter that wraps at the wrong count, or never wraps, would put 4'b0001 on the wrong frame. It stalls `m_tready` in the middle of a frame, where a design that lets the channel counter move would change or lose words. It changes `chan_cfg` right after capture, which shows whether the count is taken from the stored set or read live. It also fills the buffer past capacity: a design that accepted the extra set would emit a third frame, and one that overwrote a queued set would corrupt a frame still waiting to leave.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

  localparam int AUD_SMP_W = 24;

  typedef enum logic [3:0] {
    PRE_BLOCK = 4'h1,
    PRE_SUB1  = 4'h2,
    PRE_SUB2  = 4'h3
  } aud_pre_e;

  typedef struct packed {
    logic                 par;
    logic                 cs;
    logic                 usr;
    logic                 vld;
    logic [AUD_SMP_W-1:0] smp;
    aud_pre_e             pre;
  } aud_word_t;

  // Parity bit that makes the covered field even.
  function automatic logic even_fill(input logic [AUD_SMP_W+2:0] bits);
    return ^bits;
  endfunction

endpackage

// File: rtl/aud_set_fifo.sv
module aud_set_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; it is only read when occupied.
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata;
  end
endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq #(
  parameter int  MAX_CH       = 8,
  parameter int  BLOCK_FRAMES = 192,
  localparam int CH_W         = $clog2(MAX_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [CH_W-1:0] last_ch,
  output logic [CH_W-1:0] ch,
  output logic            frame_end,
  output logic            blk_first
);
  localparam int FC_W = $clog2(BLOCK_FRAMES);

  logic [CH_W-1:0] ch_q, ch_d;
  logic [FC_W-1:0] fc_q, fc_d;
  logic            ch_en, fc_en;

  assign ch        = ch_q;
  assign frame_end = adv & (ch_q == last_ch);
  assign blk_first = (fc_q == '0);
  assign ch_en     = adv;
  assign fc_en     = frame_end;

  always_comb begin
    ch_d = frame_end ? '0 : ch_q + 1'b1;
    fc_d = (fc_q == FC_W'(BLOCK_FRAMES - 1)) ? '0 : fc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
      fc_q <= '0;
    end else begin
      if (ch_en) ch_q <= ch_d;
      if (fc_en) fc_q <= fc_d;
    end
  end
endmodule

// File: rtl/aud_word_build.sv
module aud_word_build
  import aud_fmt_pkg::*;
#(
  parameter int  MAX_CH = 8,
  localparam int CH_W   = $clog2(MAX_CH)
) (
  input  logic [AUD_SMP_W-1:0] smp,
  input  logic                 vld,
  input  logic                 usr,
  input  logic                 cs,
  input  logic [CH_W-1:0]      ch,
  input  logic                 blk_first,
  output logic [31:0]          word
);
  aud_word_t w;

  always_comb begin
    w.smp = smp;
    w.vld = vld;
    w.usr = usr;
    w.cs  = cs;
    w.par = even_fill({cs, usr, vld, smp});
    if (ch[0])                       w.pre = PRE_SUB2;
    else if (ch == '0 && blk_first)  w.pre = PRE_BLOCK;
    else                             w.pre = PRE_SUB1;
  end

  assign word = w;
endmodule

// File: rtl/aud_subframe_packer.sv
module aud_subframe_packer
  import aud_fmt_pkg::*;
#(
  parameter int  MAX_CH       = 8,
  parameter int  BUF_SETS     = 2,
  parameter int  BLOCK_FRAMES = 192,
  localparam int CH_W         = $clog2(MAX_CH),
  localparam int SMP_W        = AUD_SMP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [CH_W-2:0]         chan_cfg,
  input  logic [MAX_CH*SMP_W-1:0] smp_data,
  input  logic [MAX_CH-1:0]       smp_vbit,
  input  logic [MAX_CH-1:0]       smp_ubit,
  input  logic [MAX_CH-1:0]       smp_cbit,
  output logic                    m_tvalid,
  input  logic                    m_tready,
  output logic [31:0]             m_tdata,
  output logic [CH_W-1:0]         m_tid,
  output logic                    ovf_flag
);
  localparam int DAT_W = MAX_CH * SMP_W;
  localparam int ENT_W = CH_W + 3 * MAX_CH + DAT_W;

  logic [ENT_W-1:0]  wr_ent, rd_ent;
  logic              buf_empty, buf_full, xfer, frame_end, blk_first;
  logic [DAT_W-1:0]  hd_data;
  logic [MAX_CH-1:0] hd_v, hd_u, hd_c;
  logic [CH_W-1:0]   hd_last, cur_ch;
  logic [SMP_W-1:0]  cur_smp;
  logic              ovf_q, ovf_d, ovf_en;

  // Last channel index = 2*(chan_cfg+1)-1.
  assign wr_ent = {{chan_cfg, 1'b1}, smp_cbit, smp_ubit, smp_vbit, smp_data};

  aud_set_fifo #(.W(ENT_W), .DEPTH(BUF_SETS)) i_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (smp_valid),
    .pop   (frame_end),
    .wdata (wr_ent),
    .rdata (rd_ent),
    .empty (buf_empty),
    .full  (buf_full)
  );

  assign hd_data = rd_ent[DAT_W-1:0];
  assign hd_v    = rd_ent[DAT_W +: MAX_CH];
  assign hd_u    = rd_ent[DAT_W + MAX_CH +: MAX_CH];
  assign hd_c    = rd_ent[DAT_W + 2 * MAX_CH +: MAX_CH];
  assign hd_last = rd_ent[ENT_W-1 -: CH_W];

  assign m_tvalid = ~buf_empty;
  assign xfer     = m_tvalid & m_tready;

  aud_frame_seq #(.MAX_CH(MAX_CH), .BLOCK_FRAMES(BLOCK_FRAMES)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (xfer),
    .last_ch   (hd_last),
    .ch        (cur_ch),
    .frame_end (frame_end),
    .blk_first (blk_first)
  );

  assign cur_smp = hd_data[int'(cur_ch) * SMP_W +: SMP_W];

  aud_word_build #(.MAX_CH(MAX_CH)) i_word (
    .smp       (cur_smp),
    .vld       (hd_v[cur_ch]),
    .usr       (hd_u[cur_ch]),
    .cs        (hd_c[cur_ch]),
    .ch        (cur_ch),
    .blk_first (blk_first),
    .word      (m_tdata)
  );

  assign m_tid = cur_ch;

  assign ovf_en = smp_valid & buf_full;
  assign ovf_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  assign ovf_flag = ovf_q;
endmodule

// File: rtl/aud_fmt_checker.sv
module aud_fmt_checker #(
  parameter int ID_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            m_tvalid,
  input logic            m_tready,
  input logic [31:0]     m_tdata,
  input logic [ID_W-1:0] m_tid,
  input logic            ovf_flag
);
  a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tid)));

  a_r2_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> ($countones(m_tdata[31:4]) % 2 == 0));

  a_r3_code_by_parity: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tid[0] ? (m_tdata[3:0] == 4'h3)
                           : (m_tdata[3:0] == 4'h1 || m_tdata[3:0] == 4'h2)));

  a_r3_block_on_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tdata[3:0] == 4'h1) |-> (m_tid == '0));

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready) |=>
      (!m_tvalid || m_tid == '0 || m_tid == $past(m_tid) + 1'b1));

  a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
endmodule

bind aud_subframe_packer aud_fmt_checker #(.ID_W(CH_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tdata  (m_tdata),
  .m_tid    (m_tid),
  .ovf_flag (ovf_flag)
);

// File: tb/test_aud_subframe_packer.sv
module test_aud_subframe_packer;
  logic         clk;
  logic         rst_n;
  logic         smp_valid;
  logic [1:0]   chan_cfg;
  logic [191:0] smp_data;
  logic [7:0]   smp_vbit, smp_ubit, smp_cbit;
  logic         m_tvalid, m_tready, ovf_flag;
  logic [31:0]  m_tdata;
  logic [2:0]   m_tid;

  int n_chk  = 0;
  int n_fail = 0;
  int tb_frame = 0;

  aud_subframe_packer i_aud_subframe_packer (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .chan_cfg(chan_cfg),
    .smp_data(smp_data), .smp_vbit(smp_vbit), .smp_ubit(smp_ubit),
    .smp_cbit(smp_cbit), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tid(m_tid), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] tb_smp(int ch, int seed);
    logic [15:0] s;
    s = 16'(seed);
    return {s[7:0], 8'(ch * 17 + 3), s[15:8] ^ 8'hC3};
  endfunction
  function automatic logic [7:0] tb_v(int seed); return 8'(seed * 37);     endfunction
  function automatic logic [7:0] tb_u(int seed); return 8'(seed * 53 + 1); endfunction
  function automatic logic [7:0] tb_c(int seed); return 8'(seed * 91 + 7); endfunction

  function automatic logic [31:0] exp_word(int ch, int seed, bit blk);
    logic [23:0] s;
    logic v, u, c, p;
    logic [3:0] pre;
    s = tb_smp(ch, seed);
    v = tb_v(seed)[ch];
    u = tb_u(seed)[ch];
    c = tb_c(seed)[ch];
    p = ^{c, u, v, s};
    pre = (ch % 2 == 1) ? 4'h3 : (blk ? 4'h1 : 4'h2);
    return {p, c, u, v, s, pre};
  endfunction

  task automatic push_set(logic [1:0] cfg, int seed);
    @(negedge clk);
    for (int ch = 0; ch < 8; ch++) smp_data[ch*24 +: 24] = tb_smp(ch, seed);
    smp_vbit  = tb_v(seed);
    smp_ubit  = tb_u(seed);
    smp_cbit  = tb_c(seed);
    chan_cfg  = cfg;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // Called at a negedge with the frame's first word on the port.
  task automatic drain_frame(int nch, int seed);
    for (int ch = 0; ch < nch; ch++) begin
      check("R4 tvalid in frame", 32'(m_tvalid), 32'd1);
      check("R4 channel id", 32'(m_tid), 32'(ch));
      check("R1 R2 R3 word", m_tdata,
            exp_word(ch, seed, (tb_frame == 0) && (ch == 0)));
      m_tready = 1'b1;
      @(negedge clk);
    end
    m_tready = 1'b0;
    tb_frame = (tb_frame + 1) % 192;
  endtask

  task automatic t_reset();
    check("R9 tvalid after reset", 32'(m_tvalid), 32'd0);
    check("R9 ovf after reset", 32'(ovf_flag), 32'd0);
  endtask

  task automatic t_stereo();
    push_set(2'b00, 11);
    drain_frame(2, 11);
    check("R5 two channels then idle", 32'(m_tvalid), 32'd0);
  endtask

  task automatic t_eight();
    push_set(2'b11, 12345);
    drain_frame(8, 12345);
    check("R5 eight channels then idle", 32'(m_tvalid), 32'd0);
  endtask

  task automatic t_cfg();
    push_set(2'b01, 777);
    chan_cfg = 2'b11;
    drain_frame(4, 777);
    check("R5 captured count 4", 32'(m_tvalid), 32'd0);
    push_set(2'b10, 4242);
    drain_frame(6, 4242);
    check("R5 count 6", 32'(m_tvalid), 32'd0);
  endtask

  task automatic t_stall();
    logic [31:0] w0;
    logic [2:0]  id0;
    push_set(2'b01, 999);
    m_tready = 1'b1;
    @(negedge clk);
    m_tready = 1'b0;
    w0  = m_tdata;
    id0 = m_tid;
    check("R6 second word first", 32'(id0), 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 hold tvalid", 32'(m_tvalid), 32'd1);
      check("R6 hold tdata", m_tdata, w0);
      check("R6 hold tid", 32'(m_tid), 32'(id0));
    end
    check("R6 word after stall", m_tdata, exp_word(1, 999, 1'b0));
    for (int ch = 1; ch < 4; ch++) begin
      check("R6 resumed id", 32'(m_tid), 32'(ch));
      check("R6 resumed word", m_tdata, exp_word(ch, 999, 1'b0));
      m_tready = 1'b1;
      @(negedge clk);
    end
    m_tready = 1'b0;
    tb_frame = (tb_frame + 1) % 192;
    check("R6 frame done", 32'(m_tvalid), 32'd0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 200; i++) begin
      push_set(2'b00, 500 + i);
      if (tb_frame == 0)
        check("R8 block start at wrap", 32'(m_tdata[3:0]), 32'h1);
      if (tb_frame == 1 || tb_frame == 191)
        check("R8 no block start", 32'(m_tdata[3:0]), 32'h2);
      drain_frame(2, 500 + i);
    end
  endtask

  task automatic t_overflow();
    m_tready = 1'b0;
    push_set(2'b00, 61);
    push_set(2'b01, 62);
    check("R7 full but no overflow", 32'(ovf_flag), 32'd0);
    push_set(2'b11, 63);
    check("R7 overflow raised", 32'(ovf_flag), 32'd1);
    drain_frame(2, 61);
    drain_frame(4, 62);
    check("R7 third set dropped", 32'(m_tvalid), 32'd0);
    check("R7 overflow sticky", 32'(ovf_flag), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    smp_valid = 1'b0;
    m_tready = 1'b0;
    chan_cfg = 2'b00;
    smp_data = '0;
    smp_vbit = '0;
    smp_ubit = '0;
    smp_cbit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stereo();
    t_eight();
    t_cfg();
    t_stall();
    t_wrap();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule